// File: doc/BRIEF.md
# Masked Control Register File

This block holds the sixteen 32-bit control registers of a processor core. Each register carries two fixed per-bit masks: a writable mask and a read-only mask. Both come from two configuration parameters: one says whether an external interrupt controller is attached, and the other says whether a memory-management unit is present. A software or debug agent writes a register by index through a valid/ready port and reads any register by index through a combinational read port. Three dedicated hardware update inputs load the exception-cause, interrupt-pending and core-identity registers directly.

On a software write, the new register value is the written data kept through the writable mask, combined with the old value kept through the read-only mask. A bit that belongs to neither mask reads as zero. A register with no bit in either mask is reserved and reads as zero. The write port never applies back-pressure: `wr_ready` is held high, and a write takes effect on the clock edge where `wr_valid` is high.

Register indices: status 0, saved status 1, break status 2, interrupt enable 3, interrupt pending 4, core identity 5, exception cause 7, page-table address 8, translation data 9, translation control 10, fault address 12. Indices 6, 11, 13, 14 and 15 are reserved. Status bit layout: PIE bit 0, user mode bit 1, exception-handling enable bit 2, interrupt-handler enable bit 3, interrupt level bits 9:4, current register set bits 15:10, previous register set bits 21:16, non-maskable flag bit 22, register-set interrupt enable bit 23. Page-table address: virtual page bits 21:2, table base bits 31:22. Translation control: dirty bit 0, permission bits 3:1, bad bit 4, double-fault bit 5, process id bits 19:6, write-enable bit 20, read bit 21, way bits 25:22.

Top module: `ctlreg_file`

## Requirements
- R1: On an accepted write (`wr_valid` high), the register at `wr_idx` becomes (wr_data AND writable mask) OR (old value AND read-only mask) at the next rising clock edge.
- R2: `rd_data` returns the register selected by `rd_idx`, masked by the union of its two masks. Reserved indices (6, 11, 13, 14, 15, plus any register whose masks are both empty in the chosen configuration) read as zero.
- R3: Registers 1, 2 and 12 are writable in all 32 bits. Registers 5 and 7 are read-only in all 32 bits. Status bit 0 is always writable.
- R4: With the interrupt controller present, status bits 23, 21:16, 9:4 and 3 are writable, and bits 22 and 15:10 are read-only. Registers 3 and 4 are reserved.
- R5: With the interrupt controller absent, status bit 23 is read-only, register 3 is writable in all 32 bits, and register 4 is read-only in all 32 bits.
- R6: With the memory-management unit present, status bits 2:1 and page-table address bits 31:2 are writable, and register 9 is writable in all 32 bits. Without it, registers 8, 9 and 10 are reserved and status bits 2:1 read as zero.
- R7: With the memory-management unit present, register 10 bits 5:0 are read-only and bits 25:6 are writable. Bits 31:26 read as zero.
- R8: While `rst_n` is low at a clock edge, every register clears to zero, except that status becomes 0x0080_0000 and the core identity register loads `core_id`.
- R9: An update input with its valid high loads its register (exception 7, pending 4, identity 5) with the full data word, without applying the masks. It wins over a software write to the same register in the same cycle.
- R10: `wr_ready` is always high. When `wr_valid` is low, `wr_data` and `wr_idx` change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| core_id | input | 32 | Identity value loaded into register 5 at reset |
| wr_valid | input | 1 | Software write request |
| wr_ready | output | 1 | Write accepted; always high |
| wr_idx | input | 4 | Index of the register to write |
| wr_data | input | 32 | Write data before masking |
| rd_idx | input | 4 | Index of the register to read |
| rd_data | output | 32 | Masked value of the selected register |
| exc_upd_valid | input | 1 | Load the exception cause register |
| exc_upd_data | input | 32 | Exception cause value |
| pend_upd_valid | input | 1 | Load the interrupt pending register |
| pend_upd_data | input | 32 | Interrupt pending value |
| id_upd_valid | input | 1 | Load the core identity register |
| id_upd_data | input | 32 | Core identity value |

## Verification
The merge property compares a register's new value with its old value. It therefore assumes that `rd_idx` stays fixed across the write edge, and that no hardware update targets the same register in that cycle. The bench holds the read index on the written register over every write and drives update inputs only in dedicated phases. The reset property assumes that `rst_n` is low at time zero, which the bench guarantees. The bench sweeps every index with several data patterns on two instances of opposite configuration, so each mask bit is covered both set and clear.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;

  localparam int IX_STATUS  = 0;
  localparam int IX_ESTAT   = 1;
  localparam int IX_BSTAT   = 2;
  localparam int IX_IENA    = 3;
  localparam int IX_IPEND   = 4;
  localparam int IX_CPUID   = 5;
  localparam int IX_EXC     = 7;
  localparam int IX_PTADDR  = 8;
  localparam int IX_TLBDATA = 9;
  localparam int IX_TLBCTL  = 10;
  localparam int IX_FAULT   = 12;

  // status fields
  localparam logic [31:0] ST_PIE  = 32'h0000_0001;
  localparam logic [31:0] ST_USR  = 32'h0000_0002;
  localparam logic [31:0] ST_EXH  = 32'h0000_0004;
  localparam logic [31:0] ST_IHE  = 32'h0000_0008;
  localparam logic [31:0] ST_ILVL = 32'h0000_03F0;
  localparam logic [31:0] ST_CSET = 32'h0000_FC00;
  localparam logic [31:0] ST_PSET = 32'h003F_0000;
  localparam logic [31:0] ST_NMI  = 32'h0040_0000;
  localparam logic [31:0] ST_RSIE = 32'h0080_0000;

  // page-table address fields
  localparam logic [31:0] PT_VPAGE = 32'h003F_FFFC;
  localparam logic [31:0] PT_BASE  = 32'hFFC0_0000;

  // translation control fields
  localparam logic [31:0] TC_DIRTY = 32'h0000_0001;
  localparam logic [31:0] TC_PERM  = 32'h0000_000E;
  localparam logic [31:0] TC_BAD   = 32'h0000_0010;
  localparam logic [31:0] TC_DBL   = 32'h0000_0020;
  localparam logic [31:0] TC_PID   = 32'h000F_FFC0;
  localparam logic [31:0] TC_WEN   = 32'h0010_0000;
  localparam logic [31:0] TC_RDEN  = 32'h0020_0000;
  localparam logic [31:0] TC_WAY   = 32'h03C0_0000;

  function automatic logic [31:0] wr_mask(int idx, bit eic, bit mmu);
    logic [31:0] m;
    m = '0;
    case (idx)
      IX_STATUS: begin
        m = ST_PIE;
        if (eic) m = m | ST_RSIE | ST_PSET | ST_ILVL | ST_IHE;
        if (mmu) m = m | ST_USR | ST_EXH;
      end
      IX_ESTAT, IX_BSTAT, IX_FAULT: m = '1;
      IX_IENA:    m = eic ? '0 : '1;
      IX_PTADDR:  m = mmu ? (PT_VPAGE | PT_BASE) : '0;
      IX_TLBDATA: m = mmu ? '1 : '0;
      IX_TLBCTL:  m = mmu ? (TC_PID | TC_WEN | TC_RDEN | TC_WAY) : '0;
      default:    m = '0;
    endcase
    return m;
  endfunction

  function automatic logic [31:0] ro_mask(int idx, bit eic, bit mmu);
    logic [31:0] m;
    m = '0;
    case (idx)
      IX_STATUS: m = eic ? (ST_NMI | ST_CSET) : ST_RSIE;
      IX_CPUID, IX_EXC: m = '1;
      IX_IPEND:  m = eic ? '0 : '1;
      IX_TLBCTL: m = mmu ? (TC_DIRTY | TC_PERM | TC_BAD | TC_DBL) : '0;
      default:   m = '0;
    endcase
    return m;
  endfunction

  function automatic logic [31:0] rst_value(int idx);
    return (idx == IX_STATUS) ? ST_RSIE : '0;
  endfunction

endpackage

// File: rtl/ctlreg_route.sv
module ctlreg_route #(
  parameter int NREG = 16,
  parameter int DW   = 32,
  localparam int IW  = $clog2(NREG)
) (
  input  logic                    wr_fire,
  input  logic [IW-1:0]           wr_idx,
  input  logic                    exc_upd_valid,
  input  logic [DW-1:0]           exc_upd_data,
  input  logic                    pend_upd_valid,
  input  logic [DW-1:0]           pend_upd_data,
  input  logic                    id_upd_valid,
  input  logic [DW-1:0]           id_upd_data,
  output logic [NREG-1:0]         sw_we,
  output logic [NREG-1:0]         hw_we,
  output logic [NREG-1:0][DW-1:0] hw_data
);
  import ctlreg_pkg::*;

  for (genvar i = 0; i < NREG; i++) begin : g_route
    assign sw_we[i] = wr_fire && (wr_idx == IW'(i));
    if (i == IX_EXC) begin : g_exc
      assign hw_we[i]   = exc_upd_valid;
      assign hw_data[i] = exc_upd_data;
    end else if (i == IX_IPEND) begin : g_pend
      assign hw_we[i]   = pend_upd_valid;
      assign hw_data[i] = pend_upd_data;
    end else if (i == IX_CPUID) begin : g_id
      assign hw_we[i]   = id_upd_valid;
      assign hw_data[i] = id_upd_data;
    end else begin : g_none
      assign hw_we[i]   = 1'b0;
      assign hw_data[i] = '0;
    end
  end
endmodule

// File: rtl/ctlreg_slot.sv
module ctlreg_slot #(
  parameter int          DW    = 32,
  parameter logic [31:0] WMASK = '0,
  parameter logic [31:0] RMASK = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] rst_val,
  input  logic          sw_we,
  input  logic [DW-1:0] sw_data,
  input  logic          hw_we,
  input  logic [DW-1:0] hw_data,
  output logic [DW-1:0] view
);
  localparam logic [DW-1:0] WM  = WMASK[DW-1:0];
  localparam logic [DW-1:0] RM  = RMASK[DW-1:0];
  localparam logic [DW-1:0] VIS = WM | RM;

  logic [DW-1:0] q;

  always_ff @(posedge clk) begin
    if (!rst_n)     q <= rst_val;
    else if (hw_we) q <= hw_data;
    else if (sw_we) q <= (sw_data & WM) | (q & RM);
  end

  assign view = q & VIS;
endmodule

// File: rtl/ctlreg_rdmux.sv
module ctlreg_rdmux #(
  parameter int NREG = 16,
  parameter int DW   = 32,
  localparam int IW  = $clog2(NREG)
) (
  input  logic [NREG-1:0][DW-1:0] views,
  input  logic [IW-1:0]           rd_idx,
  output logic [DW-1:0]           rd_data
);
  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NREG; i++) begin
      if (rd_idx == IW'(i)) rd_data = views[i];
    end
  end
endmodule

// File: rtl/ctlreg_file.sv
module ctlreg_file #(
  parameter bit  HAS_EIC = 1'b0,
  parameter bit  HAS_MMU = 1'b1,
  parameter int  NREG    = 16,
  parameter int  DW      = 32,
  localparam int IW      = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] core_id,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_data,
  input  logic          exc_upd_valid,
  input  logic [DW-1:0] exc_upd_data,
  input  logic          pend_upd_valid,
  input  logic [DW-1:0] pend_upd_data,
  input  logic          id_upd_valid,
  input  logic [DW-1:0] id_upd_data
);
  import ctlreg_pkg::*;

  logic [NREG-1:0]         sw_we;
  logic [NREG-1:0]         hw_we;
  logic [NREG-1:0][DW-1:0] hw_data;
  logic [NREG-1:0][DW-1:0] views;

  assign wr_ready = 1'b1;

  ctlreg_route #(.NREG(NREG), .DW(DW)) u_route (
    .wr_fire        (wr_valid && wr_ready),
    .wr_idx         (wr_idx),
    .exc_upd_valid  (exc_upd_valid),
    .exc_upd_data   (exc_upd_data),
    .pend_upd_valid (pend_upd_valid),
    .pend_upd_data  (pend_upd_data),
    .id_upd_valid   (id_upd_valid),
    .id_upd_data    (id_upd_data),
    .sw_we          (sw_we),
    .hw_we          (hw_we),
    .hw_data        (hw_data)
  );

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [31:0] WM = wr_mask(i, HAS_EIC, HAS_MMU);
    localparam logic [31:0] RM = ro_mask(i, HAS_EIC, HAS_MMU);
    logic [DW-1:0] rv;
    if (i == IX_CPUID) begin : g_rv_id
      assign rv = core_id;
    end else begin : g_rv_k
      localparam logic [31:0] RK = rst_value(i);
      assign rv = RK[DW-1:0];
    end
    ctlreg_slot #(.DW(DW), .WMASK(WM), .RMASK(RM)) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .rst_val (rv),
      .sw_we   (sw_we[i]),
      .sw_data (wr_data),
      .hw_we   (hw_we[i]),
      .hw_data (hw_data[i]),
      .view    (views[i])
    );
  end

  ctlreg_rdmux #(.NREG(NREG), .DW(DW)) u_rdmux (
    .views   (views),
    .rd_idx  (rd_idx),
    .rd_data (rd_data)
  );
endmodule

// File: rtl/ctlreg_file_chk.sv
module ctlreg_file_chk #(
  parameter bit HAS_EIC = 1'b0,
  parameter bit HAS_MMU = 1'b1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_valid,
  input logic [3:0]  wr_idx,
  input logic [31:0] wr_data,
  input logic [3:0]  rd_idx,
  input logic [31:0] rd_data,
  input logic        exc_upd_valid,
  input logic [31:0] exc_upd_data,
  input logic        pend_upd_valid,
  input logic [31:0] pend_upd_data,
  input logic        id_upd_valid
);
  import ctlreg_pkg::*;

  logic hw_hit;
  assign hw_hit = (exc_upd_valid  && rd_idx == 4'(IX_EXC))   ||
                  (pend_upd_valid && rd_idx == 4'(IX_IPEND)) ||
                  (id_upd_valid   && rd_idx == 4'(IX_CPUID));

  // R1: merge of written data with retained read-only bits
  a_r1_merge: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_idx == rd_idx && !hw_hit) |=>
      (rd_idx != $past(rd_idx) ||
       rd_data == (($past(wr_data) & wr_mask(int'($past(rd_idx)), HAS_EIC, HAS_MMU)) |
                   ($past(rd_data) & ro_mask(int'($past(rd_idx)), HAS_EIC, HAS_MMU)))));

  // R2: index with empty masks reads zero
  a_r2_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_mask(int'(rd_idx), HAS_EIC, HAS_MMU) | ro_mask(int'(rd_idx), HAS_EIC, HAS_MMU)) == '0)
      |-> rd_data == '0);

  // R8: status value while and right after reset
  a_r8_status_rst: assert property (@(posedge clk)
    (!rst_n && rd_idx == 4'(IX_STATUS)) |=>
      (rd_idx != 4'(IX_STATUS) || rd_data == ST_RSIE));

  // R9: exception update loads the full word and wins over software
  a_r9_exc_load: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_upd_valid && rd_idx == 4'(IX_EXC)) |=>
      (rd_idx != 4'(IX_EXC) || rd_data == $past(exc_upd_data)));

  // R9: pending update visible through its read-only mask
  a_r9_pend_load: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_upd_valid && rd_idx == 4'(IX_IPEND)) |=>
      (rd_idx != 4'(IX_IPEND) ||
       rd_data == ($past(pend_upd_data) & ro_mask(IX_IPEND, HAS_EIC, HAS_MMU))));
endmodule

bind ctlreg_file ctlreg_file_chk #(.HAS_EIC(HAS_EIC), .HAS_MMU(HAS_MMU)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .wr_valid       (wr_valid),
  .wr_idx         (wr_idx),
  .wr_data        (wr_data),
  .rd_idx         (rd_idx),
  .rd_data        (rd_data),
  .exc_upd_valid  (exc_upd_valid),
  .exc_upd_data   (exc_upd_data),
  .pend_upd_valid (pend_upd_valid),
  .pend_upd_data  (pend_upd_data),
  .id_upd_valid   (id_upd_valid)
);

// File: tb/ctlreg_file_bench.sv
`timescale 1ns/1ps
module ctlreg_file_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] core_id = 32'h0000_0003;
  logic        wr_valid = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  rd_idx = '0;
  logic        exc_upd_valid = 1'b0;
  logic [31:0] exc_upd_data = '0;
  logic        pend_upd_valid = 1'b0;
  logic [31:0] pend_upd_data = '0;
  logic        id_upd_valid = 1'b0;
  logic [31:0] id_upd_data = '0;
  logic        rdy_a, rdy_b;
  logic [31:0] rd_a, rd_b;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] st_a [16];
  logic [31:0] st_b [16];

  always #2.5 clk = ~clk;

  // instance A: no interrupt controller, MMU present
  ctlreg_file #(.HAS_EIC(1'b0), .HAS_MMU(1'b1)) u_ctlreg_file (
    .clk(clk), .rst_n(rst_n), .core_id(core_id),
    .wr_valid(wr_valid), .wr_ready(rdy_a), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_data(rd_a),
    .exc_upd_valid(exc_upd_valid), .exc_upd_data(exc_upd_data),
    .pend_upd_valid(pend_upd_valid), .pend_upd_data(pend_upd_data),
    .id_upd_valid(id_upd_valid), .id_upd_data(id_upd_data));

  // instance B: interrupt controller present, no MMU
  ctlreg_file #(.HAS_EIC(1'b1), .HAS_MMU(1'b0)) u_ctlreg_file_alt (
    .clk(clk), .rst_n(rst_n), .core_id(core_id),
    .wr_valid(wr_valid), .wr_ready(rdy_b), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_data(rd_b),
    .exc_upd_valid(exc_upd_valid), .exc_upd_data(exc_upd_data),
    .pend_upd_valid(pend_upd_valid), .pend_upd_data(pend_upd_data),
    .id_upd_valid(id_upd_valid), .id_upd_data(id_upd_data));

  // expected masks, from the requirements
  function automatic logic [31:0] ew(int i, bit eic, bit mmu);
    case (i)
      0:  return 32'h1 | (eic ? 32'h00BF_03F8 : 32'h0) | (mmu ? 32'h6 : 32'h0);
      1, 2, 12: return 32'hFFFF_FFFF;
      3:  return eic ? 32'h0 : 32'hFFFF_FFFF;
      8:  return mmu ? 32'hFFFF_FFFC : 32'h0;
      9:  return mmu ? 32'hFFFF_FFFF : 32'h0;
      10: return mmu ? 32'h03FF_FFC0 : 32'h0;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] er(int i, bit eic, bit mmu);
    case (i)
      0:  return eic ? 32'h0040_FC00 : 32'h0080_0000;
      4:  return eic ? 32'h0 : 32'hFFFF_FFFF;
      5, 7: return 32'hFFFF_FFFF;
      10: return mmu ? 32'h0000_003F : 32'h0;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag(int i, bit eic, bit mmu);
    if ((ew(i, eic, mmu) | er(i, eic, mmu)) == 0) return "R2";
    case (i)
      0:  return eic ? "R4" : "R5";
      1, 2, 5, 7, 12: return "R3";
      3, 4: return "R5";
      8, 9: return "R6";
      10: return "R7";
      default: return "R1";
    endcase
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 16; i++) begin
      st_a[i] = (i == 0) ? 32'h0080_0000 : (i == 5) ? core_id : 32'h0;
      st_b[i] = st_a[i];
    end
  endtask

  task automatic read_all(string req);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      rd_idx = 4'(i);
      #1;
      check((req == "") ? tag(i, 1'b0, 1'b1) : req, $sformatf("A idx %0d", i),
            rd_a, st_a[i] & (ew(i, 1'b0, 1'b1) | er(i, 1'b0, 1'b1)));
      check((req == "") ? tag(i, 1'b1, 1'b0) : req, $sformatf("B idx %0d", i),
            rd_b, st_b[i] & (ew(i, 1'b1, 1'b0) | er(i, 1'b1, 1'b0)));
    end
  endtask

  task automatic sw_write(int i, logic [31:0] d);
    @(negedge clk);
    rd_idx = 4'(i);
    wr_idx = 4'(i);
    wr_data = d;
    wr_valid = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0;
    st_a[i] = (d & ew(i, 1'b0, 1'b1)) | (st_a[i] & er(i, 1'b0, 1'b1));
    st_b[i] = (d & ew(i, 1'b1, 1'b0)) | (st_b[i] & er(i, 1'b1, 1'b0));
  endtask

  initial begin
    #200000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    read_all("R8");
    check("R10", "ready A", {31'b0, rdy_a}, 32'h1);
    check("R10", "ready B", {31'b0, rdy_b}, 32'h1);

    // sweep patterns over every index; R1 merge rule
    for (int p = 0; p < 6; p++) begin
      logic [31:0] pat;
      pat = (p == 0) ? 32'hFFFF_FFFF : (p == 1) ? 32'h0 :
            (32'h9E37_79B9 * p) ^ (32'h5A5A_A5A5 >> p);
      for (int i = 0; i < 16; i++) sw_write(i, pat ^ (32'h0101_0101 * i));
      read_all("");
    end
    for (int i = 0; i < 16; i++) sw_write(i, 32'hFFFF_FFFF);
    read_all("R1");

    // R10: no valid, no change
    @(negedge clk);
    wr_valid = 1'b0; wr_idx = 4'd1; wr_data = 32'h0; rd_idx = 4'd1;
    @(negedge clk);
    #1;
    check("R10", "idle write A", rd_a, st_a[1]);
    check("R10", "idle write B", rd_b, st_b[1]);

    // R9: exception update against same-cycle software write
    @(negedge clk);
    rd_idx = 4'd7; wr_idx = 4'd7; wr_data = 32'h1111_2222; wr_valid = 1'b1;
    exc_upd_valid = 1'b1; exc_upd_data = 32'hCAFE_0007;
    @(negedge clk);
    wr_valid = 1'b0; exc_upd_valid = 1'b0;
    #1;
    check("R9", "exc A", rd_a, 32'hCAFE_0007);
    check("R9", "exc B", rd_b, 32'hCAFE_0007);
    st_a[7] = 32'hCAFE_0007; st_b[7] = 32'hCAFE_0007;

    // R9: pending and identity updates
    @(negedge clk);
    rd_idx = 4'd4;
    pend_upd_valid = 1'b1; pend_upd_data = 32'h8000_00F1;
    id_upd_valid = 1'b1; id_upd_data = 32'h0000_00A5;
    wr_valid = 1'b1; wr_idx = 4'd5; wr_data = 32'h0;
    @(negedge clk);
    pend_upd_valid = 1'b0; id_upd_valid = 1'b0; wr_valid = 1'b0;
    #1;
    check("R9", "pend A", rd_a, 32'h8000_00F1);
    check("R9", "pend B", rd_b, 32'h0);
    st_a[4] = 32'h8000_00F1; st_b[4] = 32'h8000_00F1;
    st_a[5] = 32'h0000_00A5; st_b[5] = 32'h0000_00A5;
    read_all("R9");

    // R8: second reset with a new identity
    @(negedge clk);
    rst_n = 1'b0; core_id = 32'h0000_0011;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    read_all("R8");

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule